// File: doc/BRIEF.md
# Periodic Up-Counting Timer with Compare Channels

This block is a periodic timer for a control or housekeeping subsystem. One counter counts up from zero to a programmed period value and then returns to zero, so it produces a fixed, repeating time base. Six compare channels share that counter. Each one holds a threshold and raises its own pending flag when the counter arrives at that threshold. The counter also flags every completed period.

The counter advances on ticks from one of three sources: two internal tick strobes, or rising edges of an external pin after a two-stage synchronizer. The selected ticks pass through a power-of-two divider and then through an expansion divider with a ratio of 1 to 8. Software drives the block through a small synchronous register port. The pending flags, gated by per-source enables, form a single interrupt request. A vector register returns an even code that identifies the highest-priority pending source, and reading it clears that one flag.

Top module: `uptimer_cc`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped and `irq` is 0.
- R2: While RUN bit0 (address 1) is 1, each divided tick increments the counter. A divided tick with the counter at or above the period (address 2) sets the counter to 0 and sets the period flag, FLAGS bit0 (address 3).
- R3: While RUN bit0 is 0, the counter and the dividers hold their values. Setting RUN bit0 again resumes counting from the held count.
- R4: Channel k (1..6) sets FLAGS bit k on the divided tick that makes the counter equal its threshold at address 7+k. This happens only when the threshold is below the period, so a threshold equal to or above the period never fires.
- R5: Writing a channel threshold clears that channel's flag. This clear wins over a set in the same cycle.
- R6: Writing FLAGS clears every flag whose data bit is 1 and leaves the others unchanged. A new event in the same cycle wins over this clear.
- R7: The vector register (address 5) reads 0 when nothing is pending. Otherwise it reads 2k for the lowest-numbered pending channel k. It reads 14 when only the period flag is pending. Enables do not affect the vector.
- R8: A vector read clears only the flag it reports.
- R9: `irq` is 1 exactly when some flag is pending and its bit in the enable register (address 4; bit0 is the period flag, bit k is channel k) is 1. It follows the flags in the same cycle.
- R10: CFG bits[1:0] (address 0) select the tick source: 0 = `tick_a`, 1 = `tick_b`, 2 = rising edges of `ext_pin`, 3 = no ticks. An unselected source has no effect.
- R11: CFG bits[3:2] = n divide by 2^n. CFG bits[6:4] = e then divide by e+1. The two dividers are cascaded.
- R12: Writing CFG resets the timer: the counter and dividers go to 0, RUN goes to 0 and the period flag clears. The period, thresholds, enables and channel flags are kept.
- R13: A read returns the addressed register on `bus_rdata` one cycle after `bus_rd`. Address 6 returns the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_a | input | 1 | Internal tick strobe, source 0 |
| tick_b | input | 1 | Internal tick strobe, source 1 |
| ext_pin | input | 1 | External clock pin, source 2 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, six channels, a 2-bit normal divider field and a 3-bit expansion field. Small periods therefore reach the wrap, the never-firing thresholds and every vector code within a few dozen ticks. The divider range from /1 to /64 is short enough that the table can cover the extremes of both dividers together with each tick source.

// File: rtl/uptimer_cc.sv
module uptimer_cc #(
  parameter int CNT_W  = 16,
  parameter int NCH    = 6,
  parameter int ND_W   = 2,
  parameter int EX_W   = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              ext_pin,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int NSRC   = NCH + 1;
  localparam int PRE_W  = (1 << ND_W) - 1;
  localparam int A_CFG  = 0;
  localparam int A_RUN  = 1;
  localparam int A_PER  = 2;
  localparam int A_FLG  = 3;
  localparam int A_IEN  = 4;
  localparam int A_VEC  = 5;
  localparam int A_CNT  = 6;
  localparam int A_THR  = 8;
  localparam int CFG_W  = 2 + ND_W + EX_W;

  logic [1:0]       src_sel;
  logic [ND_W-1:0]  nd;
  logic [EX_W-1:0]  ex;
  logic             run;
  logic [CNT_W-1:0] period, cnt, cnt_nxt;
  logic [CNT_W-1:0] thr [NCH];
  logic [NSRC-1:0]  flg, ien, vec_hit, vec_clr;
  logic [CNT_W-1:0] vec_code, rd_mux;
  logic [PRE_W-1:0] pre1, nd_lim;
  logic [EX_W-1:0]  pre2;
  logic [2:0]       ext_s;
  logic             src_tick, div1_tick, cnt_tick, wrap;
  logic             wr_cfg, wr_run, wr_per, wr_flg, wr_ien, rd_vec;
  logic [NCH-1:0]   thr_wr;

  assign wr_cfg = bus_wr && bus_addr == ADDR_W'(A_CFG);
  assign wr_run = bus_wr && bus_addr == ADDR_W'(A_RUN);
  assign wr_per = bus_wr && bus_addr == ADDR_W'(A_PER);
  assign wr_flg = bus_wr && bus_addr == ADDR_W'(A_FLG);
  assign wr_ien = bus_wr && bus_addr == ADDR_W'(A_IEN);
  assign rd_vec = bus_rd && bus_addr == ADDR_W'(A_VEC);

  // tick source selection and external pin synchronizer
  always_ff @(posedge clk) begin
    if (!rst_n) ext_s <= '0;
    else        ext_s <= {ext_s[1:0], ext_pin};
  end

  always_comb begin
    case (src_sel)
      2'd0:    src_tick = tick_a;
      2'd1:    src_tick = tick_b;
      2'd2:    src_tick = ext_s[1] & ~ext_s[2];
      default: src_tick = 1'b0;
    endcase
  end

  // cascaded dividers
  assign nd_lim    = ~(~PRE_W'(0) << nd);
  assign div1_tick = run && src_tick && pre1 == nd_lim;
  assign cnt_tick  = div1_tick && pre2 == ex;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_cfg) begin
      pre1 <= '0;
      pre2 <= '0;
    end else begin
      if (run && src_tick) pre1 <= div1_tick ? '0 : pre1 + 1'b1;
      if (div1_tick)       pre2 <= cnt_tick ? '0 : pre2 + 1'b1;
    end
  end

  // configuration, run control, period, enables
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel <= '0;
      nd      <= '0;
      ex      <= '0;
      run     <= 1'b0;
      period  <= '0;
      ien     <= '0;
    end else begin
      if (wr_cfg) begin
        src_sel <= bus_wdata[1:0];
        nd      <= bus_wdata[2 +: ND_W];
        ex      <= bus_wdata[2+ND_W +: EX_W];
        run     <= 1'b0;
      end else if (wr_run) begin
        run     <= bus_wdata[0];
      end
      if (wr_per) period <= bus_wdata;
      if (wr_ien) ien    <= bus_wdata[NSRC-1:0];
    end
  end

  // shared up counter
  assign wrap    = cnt >= period;
  assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_cfg) cnt <= '0;
    else if (cnt_tick)    cnt <= cnt_nxt;
  end

  // thresholds and pending flags
  generate
    for (genvar k = 0; k < NCH; k++) begin : g_thr
      assign thr_wr[k] = bus_wr && bus_addr == ADDR_W'(A_THR + k);
      always_ff @(posedge clk) begin
        if (!rst_n)         thr[k] <= '0;
        else if (thr_wr[k]) thr[k] <= bus_wdata;
      end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flg
      logic set_i, soft_clr_i;
      assign soft_clr_i = (wr_flg && bus_wdata[i]) || vec_clr[i];
      if (i == 0) begin : g_main
        assign set_i = cnt_tick && wrap;
        always_ff @(posedge clk) begin
          if (!rst_n || wr_cfg) flg[i] <= 1'b0;
          else if (set_i)       flg[i] <= 1'b1;
          else if (soft_clr_i)  flg[i] <= 1'b0;
        end
      end else begin : g_ch
        assign set_i = cnt_tick && cnt_nxt == thr[i-1] && thr[i-1] < period;
        always_ff @(posedge clk) begin
          if (!rst_n || thr_wr[i-1]) flg[i] <= 1'b0;
          else if (set_i)            flg[i] <= 1'b1;
          else if (soft_clr_i)       flg[i] <= 1'b0;
        end
      end
    end
  endgenerate

  // priority vector: lowest channel first, period event last
  always_comb begin
    vec_code = '0;
    vec_hit  = '0;
    if (flg[0]) begin
      vec_code = CNT_W'(2 * NSRC);
      vec_hit  = NSRC'(1);
    end
    for (int i = NCH; i >= 1; i--) begin
      if (flg[i]) begin
        vec_code = CNT_W'(2 * i);
        vec_hit  = NSRC'(1) << i;
      end
    end
  end

  assign vec_clr = rd_vec ? vec_hit : '0;
  assign irq     = |(flg & ien);

  // register read port
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_CFG): rd_mux = CNT_W'({ex, nd, src_sel});
      ADDR_W'(A_RUN): rd_mux = CNT_W'(run);
      ADDR_W'(A_PER): rd_mux = period;
      ADDR_W'(A_FLG): rd_mux = CNT_W'(flg);
      ADDR_W'(A_IEN): rd_mux = CNT_W'(ien);
      ADDR_W'(A_VEC): rd_mux = vec_code;
      ADDR_W'(A_CNT): rd_mux = cnt;
      default: begin
        for (int k = 0; k < NCH; k++)
          if (bus_addr == ADDR_W'(A_THR + k)) rd_mux = thr[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // assertions
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && cnt == period && !wr_cfg) |=> (cnt == '0 && flg[0]));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cfg) |=> $stable(cnt));

  a_r7_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && flg == '0) |=> bus_rdata == '0);

  a_r12_cfg_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cnt == '0 && !run && !flg[0]));

  a_r9_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flg != '0 && ien != '0));

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_chk
      a_r5_thr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr[k] |=> !flg[k+1]);
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{CFG_W'(0)};

endmodule

// File: tb/test_uptimer_cc.sv
module test_uptimer_cc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_a = 1'b0, tick_b = 1'b0, ext_pin = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uptimer_cc i_uptimer_cc (
    .clk, .rst_n, .tick_a, .tick_b, .ext_pin,
    .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .irq
  );

  // columns: src, pulsed line (0=a,1=b), nd, ex, period, pulses, exp count, exp period flag
  localparam int NT = 8;
  localparam int TBL [NT][8] = '{
    '{0, 0, 0, 0,  10,  5, 5, 0},
    '{1, 1, 0, 0,   3,  4, 0, 1},
    '{0, 0, 1, 0, 100,  9, 4, 0},
    '{0, 0, 2, 2, 100, 25, 2, 0},
    '{1, 1, 0, 7,   1, 24, 1, 1},
    '{0, 0, 3, 0,   0, 16, 0, 1},
    '{3, 0, 0, 0,   5, 10, 0, 0},
    '{1, 0, 0, 0,   5,  6, 0, 0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int line, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line == 0) tick_a = 1'b1; else tick_b = 1'b1;
      @(negedge clk);
      tick_a = 1'b0; tick_b = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pin_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      repeat (3) @(negedge clk);
      ext_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic rdchk(input string req, input int a, input int exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, 16'(exp));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 16'(irq), 16'd0);
    rdchk("R1 cfg", 0, 0);
    rdchk("R1 run", 1, 0);
    rdchk("R1 period", 2, 0);
    rdchk("R1 flags", 3, 0);
    rdchk("R1 vector", 5, 0);
    rdchk("R1 count", 6, 0);

    // table: R2 counting/wrap, R10 source select, R11 dividers, R13 read
    for (int t = 0; t < NT; t++) begin
      wr(0, TBL[t][0] | (TBL[t][2] << 2) | (TBL[t][3] << 4));
      wr(2, TBL[t][4]);
      wr(1, 1);
      pulse(TBL[t][1], TBL[t][5]);
      rd(6, v);
      check($sformatf("R2/R10/R11 row %0d count", t), v, 16'(TBL[t][6]));
      rd(3, v);
      check($sformatf("R2 row %0d period flag", t), {15'd0, v[0]}, 16'(TBL[t][7]));
    end

    // R4 compare channels
    wr(0, 0);
    wr(3, 16'h7F);
    wr(2, 10);
    wr(8, 5); wr(9, 3); wr(10, 10); wr(11, 12); wr(12, 0); wr(13, 0);
    wr(4, 0);
    wr(1, 1);
    pulse(0, 4);
    rdchk("R4 ch2 at 3", 3, 16'h04);
    pulse(0, 2);
    rdchk("R4 ch1 at 5", 3, 16'h06);
    pulse(0, 5);
    rdchk("R4 wrap, thr>=period silent", 3, 16'h67);
    rdchk("R2 count after wrap", 6, 0);

    // R7 / R8 vector order and clear
    rdchk("R7 vector ch1", 5, 2);
    rdchk("R8 only ch1 cleared", 3, 16'h65);
    rdchk("R7 vector ch2", 5, 4);
    rdchk("R7 vector ch5", 5, 10);
    rdchk("R7 vector ch6", 5, 12);
    rdchk("R8 only main left", 3, 16'h01);
    rdchk("R7 vector main", 5, 14);
    rdchk("R7 vector empty", 5, 0);

    // R9 irq gating
    wr(4, 16'h04);
    pulse(0, 3);
    @(negedge clk);
    check("R9 irq enabled ch2", 16'(irq), 16'd1);
    wr(4, 16'h02);
    check("R9 irq masked", 16'(irq), 16'd0);

    // R5 threshold write clears
    wr(9, 3);
    rdchk("R5 flag cleared by thr write", 3, 0);

    // R6 write-one-to-clear
    pulse(0, 8);
    rdchk("R6 flags before clear", 3, 16'h63);
    wr(3, 16'h01);
    rdchk("R6 partial clear", 3, 16'h62);
    wr(3, 16'h62);
    rdchk("R6 full clear", 3, 0);

    // R3 stop and resume
    pulse(0, 2);
    wr(1, 0);
    pulse(0, 3);
    rdchk("R3 held while stopped", 6, 2);
    wr(1, 1);
    pulse(0, 1);
    rdchk("R3 resumed", 6, 3);

    // R12 configuration reset
    wr(0, 16'h04);
    rdchk("R12 count cleared", 6, 0);
    rdchk("R12 run cleared", 1, 0);
    rdchk("R12 period kept", 2, 10);
    rdchk("R12 cfg readback", 0, 16'h04);
    rdchk("R12 threshold kept", 8, 5);

    // R10 external pin source
    wr(0, 16'h02);
    wr(1, 1);
    pin_edges(3);
    pulse(0, 2);
    repeat (4) @(negedge clk);
    rdchk("R10 ext pin edges counted", 6, 3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule